// File: doc/BRIEF.md
# Recording Unit Write-Gate Timer

This block opens and closes the laser write window for one recording unit on a wobbled-groove optical disc. A recording unit covers M error-correction blocks. It begins with a short run of linking channel bits, which belong to the block before it. It ends one byte short, because the last channel bits of the final block are never written. All timing is counted in channel-bit clock enables, and the channel-bit clock is assumed to be phase locked to the wobble.

A recording starts only at a fixed position in the pregroove. The reference is an addressing-word sync whose two least significant address bits are zero. The block counts wobble zero crossings from that sync and takes crossing number 15 as the reference. It then waits a fixed number of channel bits and raises the gate.

Software or a sequencer arms the block with a start request that carries the block count M. The block then waits for the next qualifying word sync. If a word sync arrives before the reference crossing, an error flag is set and the block waits again. While the gate is open, the block reports the running channel-bit index and marks the linking bits at the head of the window.

Top module: `ru_write_gate`

## Requirements
- R1: After reset, wr_gate, link_phase and miss_err are 0 and bit_idx is 0.
- R2: A start_req is accepted only while the block is idle and blk_cnt is non-zero. A start_req with blk_cnt equal to 0, or one that arrives while the block is armed or writing, has no effect.
- R3: After an accepted start, only a word_sync pulse with word_lsb equal to 2'b00 begins the reference search. Word syncs with any other word_lsb value are ignored while waiting.
- R4: The wob_zc pulses after the qualifying word sync are numbered from 0. Pulse number 15 is the reference. Fewer than 16 pulses never open the gate.
- R5: wr_gate rises after exactly 8 channel-bit enables have been consumed following the reference pulse. An enable in the same cycle as the reference pulse is not counted.
- R6: wr_gate stays high for exactly 8 + M*BLK_BITS - 8 channel-bit enables, then falls, and the block returns to idle.
- R7: While wr_gate is high, bit_idx equals the number of channel-bit enables already consumed in the window, starting at 0, and holds between enables. bit_idx is 0 while the gate is low.
- R8: link_phase is high exactly while wr_gate is high and bit_idx is below 8, which covers the first 8 gated channel bits.
- R9: A word_sync pulse during the reference search sets miss_err, and the gate stays low. If that sync has word_lsb 2'b00, the search restarts from it; otherwise the block waits for a new qualifying sync. miss_err stays set until the next accepted start clears it.
- R10: wr_gate never rises unless a start has been accepted since the last window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per channel bit |
| wob_zc | input | 1 | Pulse at the mid-wobble zero crossing |
| word_sync | input | 1 | Pulse at an addressing-word sync |
| word_lsb | input | 2 | Two lowest address bits of that word, valid with word_sync |
| start_req | input | 1 | Request to record one unit |
| blk_cnt | input | M_W | Number of blocks M in the unit |
| wr_gate | output | 1 | Write enable window |
| link_phase | output | 1 | High during the leading linking bits |
| bit_idx | output | IDX_W | Channel-bit index inside the window |
| miss_err | output | 1 | Reference missed: word sync seen before wobble 15 |

## Verification
The bench targets the off-by-one traps in this block.
- It sends exactly 15 crossings and checks that the gate stays shut. A design that counted crossings from 1 would open one wobble early.
- It measures the enables between the reference pulse and the gate edge. A design that counted the enable in the reference cycle would start one bit early.
- It measures the window length for M of 1, 3 and 15. A design that forgot the 8-bit tail drop, or that double-counted the link bits, would give the wrong length.
- It sends a non-qualifying word sync, a start with M of zero, and a start during a write. A design that took any of these would open an unexpected window.
- It sends a word sync partway through the reference search. A design that lost that event would leave miss_err low or open a window anyway.

// File: rtl/ru_write_gate.sv
module ru_write_gate #(
  parameter int BLK_BITS   = 619008,
  parameter int M_W        = 4,
  parameter int LINK_BITS  = 8,
  parameter int TAIL_BITS  = 8,
  parameter int REF_WOBBLE = 15,
  parameter int START_OFS  = 8,
  localparam int LEN_MAX   = LINK_BITS + ((1 << M_W) - 1) * BLK_BITS,
  localparam int IDX_W     = $clog2(LEN_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             wob_zc,
  input  logic             word_sync,
  input  logic [1:0]       word_lsb,
  input  logic             start_req,
  input  logic [M_W-1:0]   blk_cnt,
  output logic             wr_gate,
  output logic             link_phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             miss_err
);
  localparam int WC_W  = $clog2(REF_WOBBLE + 1);
  localparam int OFS_W = $clog2(START_OFS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_WOBBLE, S_OFFSET, S_WRITE} state_t;

  state_t           state;
  logic [WC_W-1:0]  wcnt;
  logic [OFS_W-1:0] ocnt;
  logic [IDX_W-1:0] last_idx;

  wire qual_sync  = word_sync && (word_lsb == 2'b00);
  wire take_start = (state == S_IDLE) && start_req && (blk_cnt != '0);

  assign wr_gate    = (state == S_WRITE);
  assign link_phase = wr_gate && (bit_idx < IDX_W'(LINK_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wcnt     <= '0;
      ocnt     <= '0;
      last_idx <= '0;
      bit_idx  <= '0;
      miss_err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (take_start) begin
          state    <= S_ARMED;
          miss_err <= 1'b0;
          last_idx <= IDX_W'(blk_cnt) * IDX_W'(BLK_BITS) + IDX_W'(LINK_BITS)
                      - IDX_W'(TAIL_BITS) - IDX_W'(1);
        end
        S_ARMED: if (qual_sync) begin
          state <= S_WOBBLE;
          wcnt  <= '0;
        end
        S_WOBBLE: begin
          if (word_sync) begin
            miss_err <= 1'b1;
            wcnt     <= '0;
            if (!qual_sync) state <= S_ARMED;
          end else if (wob_zc) begin
            if (wcnt == WC_W'(REF_WOBBLE)) begin
              state <= S_OFFSET;
              ocnt  <= '0;
            end else begin
              wcnt <= wcnt + WC_W'(1);
            end
          end
        end
        S_OFFSET: if (bit_en) begin
          if (ocnt == OFS_W'(START_OFS - 1)) begin
            state   <= S_WRITE;
            bit_idx <= '0;
          end else begin
            ocnt <= ocnt + OFS_W'(1);
          end
        end
        S_WRITE: if (bit_en) begin
          if (bit_idx == last_idx) begin
            state   <= S_IDLE;
            bit_idx <= '0;
          end else begin
            bit_idx <= bit_idx + IDX_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module ru_write_gate_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          word_sync,
  input logic          wr_gate,
  input logic          link_phase,
  input logic [IW-1:0] bit_idx,
  input logic          miss_err
);
  // R7
  idx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gate |-> bit_idx == '0);
  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate && !bit_en |=> wr_gate && $stable(bit_idx));
  // R8
  link_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_phase |-> wr_gate);
  // R5
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_gate) |-> $past(bit_en) && bit_idx == '0);
  // R6
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_gate) |-> $past(bit_en));
  // R9
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_err) |-> $past(word_sync));
endmodule

bind ru_write_gate ru_write_gate_chk #(.IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_sync(word_sync),
  .wr_gate(wr_gate), .link_phase(link_phase), .bit_idx(bit_idx),
  .miss_err(miss_err)
);

// File: tb/ru_write_gate_tb.sv
module ru_write_gate_tb;
  localparam int BLK = 64;
  localparam int MW  = 4;
  localparam int IW  = $clog2(8 + 15 * BLK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, wob_zc = 1'b0, word_sync = 1'b0, start_req = 1'b0;
  logic [1:0] word_lsb = 2'b00;
  logic [MW-1:0] blk_cnt = '0;
  logic wr_gate, link_phase, miss_err;
  logic [IW-1:0] bit_idx;

  ru_write_gate #(.BLK_BITS(BLK), .M_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wob_zc(wob_zc),
    .word_sync(word_sync), .word_lsb(word_lsb), .start_req(start_req),
    .blk_cnt(blk_cnt), .wr_gate(wr_gate), .link_phase(link_phase),
    .bit_idx(bit_idx), .miss_err(miss_err)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, windows = 0;
  int exp_q[$];
  bit ref_mark = 1'b0, done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_start(int m);
    blk_cnt = MW'(m); start_req = 1'b1; step(); start_req = 1'b0; step();
  endtask

  task automatic do_sync(logic [1:0] lsb);
    word_lsb = lsb; word_sync = 1'b1; step(); word_sync = 1'b0; step();
  endtask

  task automatic wobbles(int n, bit mark_last);
    for (int i = 0; i < n; i++) begin
      step(3);
      wob_zc = 1'b1; ref_mark = mark_last && (i == n - 1);
      step();
      wob_zc = 1'b0; ref_mark = 1'b0;
    end
  endtask

  task automatic full_run(int m);
    exp_q.push_back(8 + m * BLK - 8);
    do_start(m);
    do_sync(2'b00);
    wobbles(16, 1'b1);
    step((m * BLK + 40) * 2);
  endtask

  initial begin
    step(1);
    forever begin @(posedge clk); #1; bit_en = ~bit_en; end
  end

  int ofs = 0, cnt = 0, linkc = 0, cur_exp = 0;
  bit ofs_on = 0, in_win = 0, idx_bad = 0, link_bad = 0;

  always @(negedge clk) if (rst_n && !done) begin
    if (wob_zc && ref_mark) begin ofs = 0; ofs_on = 1; end
    else if (ofs_on && !wr_gate && bit_en) ofs++;
    if (wr_gate && !in_win) begin
      in_win = 1; cnt = 0; linkc = 0; idx_bad = 0; link_bad = 0; windows++;
      if (exp_q.size() == 0) begin check(0, "R10 unexpected window", 1, 0); cur_exp = -1; end
      else cur_exp = exp_q.pop_front();
      check(ofs_on && ofs == 8, "R5 start offset", ofs, 8);
      ofs_on = 0;
    end
    if (wr_gate) begin
      if (int'(bit_idx) != cnt) idx_bad = 1;
      if (link_phase != (cnt < 8)) link_bad = 1;
      if (bit_en) begin if (link_phase) linkc++; cnt++; end
    end else if (in_win) begin
      in_win = 0;
      check(cnt == cur_exp, "R6 window length", cnt, cur_exp);
      check(!idx_bad, "R7 index sequence", idx_bad, 0);
      check(!link_bad && linkc == 8, "R8 link bits", linkc, 8);
    end
  end

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int w0;
  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    // R1
    check(!wr_gate && !link_phase && !miss_err && bit_idx == '0, "R1 reset",
          {wr_gate, link_phase, miss_err}, 0);

    full_run(1);
    full_run(3);

    // R4: 15 crossings do not open, the 16th does
    exp_q.push_back(2 * BLK);
    do_start(2); do_sync(2'b00);
    w0 = windows;
    wobbles(15, 1'b0); step(60);
    check(windows == w0, "R4 early crossing", windows - w0, 0);
    wobbles(1, 1'b1); step((2 * BLK + 40) * 2);
    check(windows == w0 + 1, "R4 reference crossing", windows - w0, 1);

    // R3: non-qualifying sync is ignored
    exp_q.push_back(BLK);
    do_start(1);
    w0 = windows;
    do_sync(2'b01); wobbles(16, 1'b0); step(60);
    check(windows == w0, "R3 lsb 01 ignored", windows - w0, 0);
    do_sync(2'b00); wobbles(16, 1'b1); step((BLK + 40) * 2);
    check(windows == w0 + 1, "R3 lsb 00 accepted", windows - w0, 1);

    // R2: zero block count ignored
    w0 = windows;
    do_start(0); do_sync(2'b00); wobbles(16, 1'b0); step(60);
    check(windows == w0, "R2 zero count", windows - w0, 0);

    // R2: start during write ignored
    exp_q.push_back(BLK);
    do_start(1); do_sync(2'b00); wobbles(16, 1'b1);
    step(40);
    blk_cnt = MW'(2); start_req = 1'b1; step(); start_req = 1'b0;
    step((BLK + 40) * 2);
    w0 = windows;
    do_sync(2'b00); wobbles(16, 1'b0); step(60);
    check(windows == w0, "R2 busy start", windows - w0, 0);

    // R9: missed reference
    exp_q.push_back(2 * BLK);
    do_start(2); do_sync(2'b00);
    w0 = windows;
    wobbles(5, 1'b0);
    do_sync(2'b10);
    check(miss_err == 1'b1, "R9 miss flag set", miss_err, 1);
    wobbles(16, 1'b0); step(60);
    check(windows == w0, "R9 gate held", windows - w0, 0);
    do_sync(2'b00); wobbles(16, 1'b1); step((2 * BLK + 40) * 2);
    check(windows == w0 + 1, "R9 recovery window", windows - w0, 1);
    check(miss_err == 1'b1, "R9 flag sticky", miss_err, 1);
    do_start(1);
    check(miss_err == 1'b0, "R9 cleared on start", miss_err, 0);
    exp_q.push_back(BLK);
    do_sync(2'b00); wobbles(16, 1'b1); step((BLK + 40) * 2);

    full_run(15);

    // R10: no start, no window
    w0 = windows;
    do_sync(2'b00); wobbles(16, 1'b0); step(60);
    check(windows == w0, "R10 no start", windows - w0, 0);
    check(exp_q.size() == 0, "R6 all windows seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule